// File: doc/BRIEF.md
# ALU Status Flag Generator

This block sits behind the adder and logic unit of a small integer datapath. Each cycle it takes two operands, an operation code, an incoming carry and an operand-size bit. It computes the byte or word result and derives the arithmetic status bits from that result and the operands: sign, zero, half-carry from the low nibble, low-byte parity, carry/borrow and signed overflow. The result and the status bits are written into a registered nine-bit flag word.

The same word also holds three control bits. A direction bit selects decrementing string pointers when set and incrementing pointers when clear. An interrupt-enable bit gates maskable interrupts. A trap bit requests a single-step interrupt after the next instruction. Software-style set and clear strobes change these bits and nothing else does. Arithmetic status is written only when the flag-write enable is high. Increment and decrement leave the carry bit as it was.

The flag word layout is: bit 0 carry, bit 1 parity, bit 2 half-carry, bit 3 zero, bit 4 sign, bit 5 trap, bit 6 interrupt enable, bit 7 direction, bit 8 overflow.

Top module: `status_flag_unit`

## Requirements
- R1: One clock edge after the inputs are applied, `result` holds the registered result of `opcode`, whatever `flag_we` is. The opcode codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 and, 5 or, 6 xor, 7 increment op_a, 8 decrement op_a. `carry_in` is used only by codes 1 and 3, and `op_b` is ignored by codes 7 and 8. With `size_word`=0 the operation uses bits 7:0 and `result[15:8]` is 0.
- R2: Sign (bit 4) equals the most significant bit of the sized result.
- R3: Zero (bit 3) is 1 exactly when every bit of the sized result is 0.
- R4: Half-carry (bit 2) is 1 on a carry out of bit 3, or a borrow into bit 3, during an arithmetic operation.
- R5: Parity (bit 1) is 1 when result bits 7:0 contain an even number of ones, in both sizes.
- R6: Carry (bit 0) is the carry out of the sized most significant bit for additions. For subtractions it is the borrow, that is, the inverted adder carry.
- R7: Overflow (bit 8) is 1 when the signed result does not fit the selected size.
- R8: Codes 4, 5 and 6 clear carry, overflow and half-carry.
- R9: Codes 7 and 8 leave carry unchanged.
- R10: While `flag_we`=0, bits 8 and 4:0 keep their values.
- R11: Direction (bit 7), interrupt enable (bit 6) and trap (bit 5) are each set by their set strobe and cleared by their clear strobe on the next edge. Set wins when both strobes are high. The bits hold otherwise, independently of `flag_we`.
- R12: A synchronous high `rst` clears every flag bit and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Incoming carry/borrow for codes 1 and 3 |
| opcode | input | 4 | Operation code |
| size_word | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| flag_we | input | 1 | Write enable for the arithmetic status bits |
| df_set | input | 1 | Set direction bit |
| df_clr | input | 1 | Clear direction bit |
| ie_set | input | 1 | Set interrupt-enable bit |
| ie_clr | input | 1 | Clear interrupt-enable bit |
| tf_set | input | 1 | Set trap bit |
| tf_clr | input | 1 | Clear trap bit |
| result | output | 16 | Registered result |
| flags | output | 9 | Registered flag word |

## Verification
The bench targets carries and signed overflow at the byte boundary, using byte operations with nonzero upper operand bits. A design that sized these at 16 bits would report a wrong sign, zero, carry or overflow, or a nonzero upper result. Subtract cases with and without an incoming borrow catch a carry that was never inverted into a borrow. Word results whose high byte is not zero catch parity taken over 16 bits. Increment and decrement vectors run after known carry states and would expose a carry that was overwritten. The directed tests cover a disabled write that still changes status bits, simultaneous set and clear strobes that resolve the wrong way, and control bits that are disturbed by arithmetic writes.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8
  } alu_op_e;

  // arithmetic status computed for one operation
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } arith_flags_t;

  // registered flag word, bit 8 down to bit 0
  typedef struct packed {
    logic of;
    logic df;
    logic ie;
    logic tf;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flag_word_t;

  localparam int N_CTRL   = 3;
  localparam int CTRL_TF  = 0;
  localparam int CTRL_IE  = 1;
  localparam int CTRL_DF  = 2;

endpackage

// File: rtl/sfu_alu_core.sv
module sfu_alu_core
  import sfu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  alu_op_e      op,
  input  logic         word,
  output logic [W-1:0] res,
  output logic [W-1:0] b_eff,
  output logic         carry,
  output logic         is_logic,
  output logic         is_sub,
  output logic         keep_cf
);
  localparam logic [W-1:0] LOW_MASK = {{(W-BW){1'b0}}, {BW{1'b1}}};

  logic [W-1:0] y;
  logic         use_c;
  logic         c0;
  logic [W:0]   sum_w;
  logic [BW:0]  sum_b;
  logic [W-1:0] ares;
  logic [W-1:0] lres;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_DEC);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    keep_cf  = (op == OP_INC) || (op == OP_DEC);
    use_c    = ((op == OP_ADC) || (op == OP_SBB)) && cin;
    b_eff    = keep_cf ? W'(1) : b;
    // subtraction is a + ~b + 1, with a borrow-in removing the +1
    y        = is_sub ? ~b_eff : b_eff;
    c0       = is_sub ^ use_c;
    sum_w    = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c0};
    sum_b    = {1'b0, a[BW-1:0]} + {1'b0, y[BW-1:0]} + {{BW{1'b0}}, c0};
    ares     = word ? sum_w[W-1:0] : {{(W-BW){1'b0}}, sum_b[BW-1:0]};
    carry    = (word ? sum_w[W] : sum_b[BW]) ^ is_sub;
    case (op)
      OP_AND:  lres = a & b;
      OP_OR:   lres = a | b;
      OP_XOR:  lres = a ^ b;
      default: lres = '0;
    endcase
    res = is_logic ? (word ? lres : (lres & LOW_MASK)) : ares;
  end

endmodule

// File: rtl/sfu_flag_calc.sv
module sfu_flag_calc
  import sfu_pkg::*;
#(
  parameter int W   = 16,
  parameter int BW  = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b_eff,
  input  logic [W-1:0]  res,
  input  logic          word,
  input  logic          carry,
  input  logic          is_logic,
  input  logic          is_sub,
  output arith_flags_t  fl
);
  logic sa, sb, sr;

  always_comb begin
    sa = word ? a[W-1]     : a[BW-1];
    sb = word ? b_eff[W-1] : b_eff[BW-1];
    sr = word ? res[W-1]   : res[BW-1];

    fl.sf = sr;
    fl.zf = word ? (res == '0) : (res[BW-1:0] == '0);
    fl.pf = ~^res[BW-1:0];
    // bit NIB of a^b^res is the carry into, or borrow out of, that bit
    fl.af = is_logic ? 1'b0 : (a[NIB] ^ b_eff[NIB] ^ res[NIB]);
    fl.cf = is_logic ? 1'b0 : carry;
    if (is_logic)
      fl.of = 1'b0;
    else if (is_sub)
      fl.of = (sa != sb) && (sr != sa);
    else
      fl.of = (sa == sb) && (sr != sa);
  end

endmodule

// File: rtl/sfu_ctrl_bank.sv
module sfu_ctrl_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= 1'b0;
      else if (set_i[i])
        q[i] <= 1'b1;
      else if (clr_i[i])
        q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int W   = 16,
  parameter int BW  = 8,
  parameter int NIB = 4,
  parameter int FW  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          carry_in,
  input  logic [3:0]    opcode,
  input  logic          size_word,
  input  logic          flag_we,
  input  logic          df_set,
  input  logic          df_clr,
  input  logic          ie_set,
  input  logic          ie_clr,
  input  logic          tf_set,
  input  logic          tf_clr,
  output logic [W-1:0]  result,
  output logic [FW-1:0] flags
);
  logic [W-1:0]      core_res;
  logic [W-1:0]      core_b;
  logic              core_carry;
  logic              core_logic;
  logic              core_sub;
  logic              core_keep;
  arith_flags_t      nxt;
  arith_flags_t      st_q;
  logic [N_CTRL-1:0] ctrl_q;
  logic [N_CTRL-1:0] ctrl_set;
  logic [N_CTRL-1:0] ctrl_clr;
  flag_word_t        word_out;

  sfu_alu_core #(.W(W), .BW(BW)) u_core (
    .a        (op_a),
    .b        (op_b),
    .cin      (carry_in),
    .op       (alu_op_e'(opcode)),
    .word     (size_word),
    .res      (core_res),
    .b_eff    (core_b),
    .carry    (core_carry),
    .is_logic (core_logic),
    .is_sub   (core_sub),
    .keep_cf  (core_keep)
  );

  sfu_flag_calc #(.W(W), .BW(BW), .NIB(NIB)) u_calc (
    .a        (op_a),
    .b_eff    (core_b),
    .res      (core_res),
    .word     (size_word),
    .carry    (core_carry),
    .is_logic (core_logic),
    .is_sub   (core_sub),
    .fl       (nxt)
  );

  always_comb begin
    ctrl_set = '0;
    ctrl_clr = '0;
    ctrl_set[CTRL_TF] = tf_set;
    ctrl_set[CTRL_IE] = ie_set;
    ctrl_set[CTRL_DF] = df_set;
    ctrl_clr[CTRL_TF] = tf_clr;
    ctrl_clr[CTRL_IE] = ie_clr;
    ctrl_clr[CTRL_DF] = df_clr;
  end

  sfu_ctrl_bank #(.N(N_CTRL)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .set_i (ctrl_set),
    .clr_i (ctrl_clr),
    .q     (ctrl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      st_q   <= '0;
    end else begin
      result <= core_res;
      if (flag_we) begin
        st_q.of <= nxt.of;
        st_q.sf <= nxt.sf;
        st_q.zf <= nxt.zf;
        st_q.af <= nxt.af;
        st_q.pf <= nxt.pf;
        st_q.cf <= core_keep ? st_q.cf : nxt.cf;
      end
    end
  end

  always_comb begin
    word_out.of = st_q.of;
    word_out.df = ctrl_q[CTRL_DF];
    word_out.ie = ctrl_q[CTRL_IE];
    word_out.tf = ctrl_q[CTRL_TF];
    word_out.sf = st_q.sf;
    word_out.zf = st_q.zf;
    word_out.af = st_q.af;
    word_out.pf = st_q.pf;
    word_out.cf = st_q.cf;
    flags = FW'(word_out);
  end

endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
  import sfu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8,
  parameter int FW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    opcode,
  input logic          size_word,
  input logic          flag_we,
  input logic          df_set,
  input logic          df_clr,
  input logic          ie_set,
  input logic          ie_clr,
  input logic          tf_set,
  input logic          tf_clr,
  input logic [W-1:0]  result,
  input logic [FW-1:0] flags
);
  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags == '0) && (result == '0));

  // R1
  byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
    !size_word |=> (result[W-1:BW] == '0));

  // R2
  sign_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> flags[4] == ($past(size_word) ? result[W-1] : result[BW-1]));

  // R3
  zero_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> flags[3] == (result == '0));

  // R5
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> flags[1] == ~^result[7:0]);

  // R8
  logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR))
      |=> (!flags[0] && !flags[2] && !flags[8]));

  // R9
  keep_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && (opcode == OP_INC || opcode == OP_DEC)) |=> $stable(flags[0]));

  // R10
  hold_status_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable({flags[8], flags[4:0]}));

  // R11
  df_set_chk: assert property (@(posedge clk) disable iff (rst)
    df_set |=> flags[7]);

  // R11
  ie_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (ie_clr && !ie_set) |=> !flags[6]);

  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(df_set || df_clr || ie_set || ie_clr || tf_set || tf_clr)
      |=> $stable(flags[7:5]));

endmodule

bind status_flag_unit sfu_checker u_chk (.*);

// File: tb/sim_status_flag_unit.sv
`timescale 1ns/1ps
module sim_status_flag_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0;
  logic [3:0]  opcode = '0;
  logic        size_word = 1'b0;
  logic        flag_we = 1'b0;
  logic        df_set = 0, df_clr = 0, ie_set = 0, ie_clr = 0, tf_set = 0, tf_clr = 0;
  logic [15:0] result;
  logic [8:0]  flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  status_flag_unit u0 (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .opcode(opcode), .size_word(size_word), .flag_we(flag_we),
    .df_set(df_set), .df_clr(df_clr), .ie_set(ie_set), .ie_clr(ie_clr),
    .tf_set(tf_set), .tf_clr(tf_clr), .result(result), .flags(flags)
  );

  // op, size, cin, a, b, expected result, expected {OF,SF,ZF,AF,PF,CF}
  localparam int NV = 19;
  localparam logic [59:0] VEC [NV] = '{
    {4'd0, 1'b1, 1'b1, 16'h1234, 16'h0001, 16'h1235, 6'b000010},
    {4'd0, 1'b0, 1'b0, 16'hAA7F, 16'h5501, 16'h0080, 6'b110100},
    {4'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 6'b001111},
    {4'd1, 1'b1, 1'b1, 16'h8000, 16'h8000, 16'h0001, 6'b100001},
    {4'd1, 1'b0, 1'b1, 16'h330F, 16'h0000, 16'h0010, 6'b000100},
    {4'd2, 1'b1, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 6'b010111},
    {4'd2, 1'b0, 1'b0, 16'h1180, 16'h2201, 16'h007F, 6'b100100},
    {4'd3, 1'b1, 1'b1, 16'h5000, 16'h2FFF, 16'h2000, 6'b000110},
    {4'd3, 1'b0, 1'b1, 16'h0010, 16'h0010, 16'h00FF, 6'b010111},
    {4'd2, 1'b1, 1'b0, 16'h4321, 16'h4321, 16'h0000, 6'b001010},
    {4'd4, 1'b1, 1'b1, 16'hF0F0, 16'h0FF0, 16'h00F0, 6'b000010},
    {4'd5, 1'b0, 1'b0, 16'hFF80, 16'h0001, 16'h0081, 6'b010010},
    {4'd6, 1'b1, 1'b0, 16'hAAAA, 16'hAAAA, 16'h0000, 6'b001010},
    {4'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 6'b001111},
    {4'd7, 1'b1, 1'b0, 16'h7FFF, 16'h1234, 16'h8000, 6'b110111},
    {4'd8, 1'b0, 1'b1, 16'h1200, 16'h1234, 16'h00FF, 6'b010111},
    {4'd8, 1'b1, 1'b0, 16'h8000, 16'h1234, 16'h7FFF, 6'b100111},
    {4'd4, 1'b0, 1'b0, 16'h773C, 16'h660F, 16'h000C, 6'b000010},
    {4'd7, 1'b0, 1'b0, 16'h55FF, 16'h1234, 16'h0000, 6'b001110}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // apply at a falling edge, one rising edge, sample at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic strobes(input logic [5:0] s);
    {df_set, df_clr, ie_set, ie_clr, tf_set, tf_clr} = s;
  endtask

  initial begin
    @(negedge clk);
    step();
    // R12 reset state
    check("R12 reset flags", {7'd0, flags}, 16'h0000);
    check("R12 reset result", result, 16'h0000);
    rst = 1'b0;

    // R1..R9 vector walk
    flag_we = 1'b1;
    for (int i = 0; i < NV; i++) begin
      opcode    = VEC[i][59:56];
      size_word = VEC[i][55];
      carry_in  = VEC[i][54];
      op_a      = VEC[i][53:38];
      op_b      = VEC[i][37:22];
      step();
      check($sformatf("R1 result vec%0d", i), result, VEC[i][21:6]);
      check($sformatf("R2-R9 status vec%0d (R2 R3 R4 R5 R6 R7 R8 R9)", i),
            {10'd0, flags[8], flags[4:0]}, {10'd0, VEC[i][5:0]});
    end

    // R10: write disabled, result still updates, status holds
    flag_we = 1'b0; opcode = 4'd0; size_word = 1'b1; op_a = 16'h0001; op_b = 16'h0001;
    step();
    check("R10 result while write disabled", result, 16'h0002);
    check("R10 status held", {7'd0, flags}, 16'h000E);

    // R11: direction set with write disabled
    strobes(6'b100000);
    step();
    check("R11 direction set", {7'd0, flags}, 16'h008E);

    // R11: set wins over clear on trap, interrupt enable set
    strobes(6'b001011);
    step();
    check("R11 set over clear", {7'd0, flags}, 16'h00EE);

    // R11 and R8: direction clear during an arithmetic write
    strobes(6'b010000);
    flag_we = 1'b1; opcode = 4'd6; size_word = 1'b0; op_a = 16'h0001; op_b = 16'h0000;
    step();
    check("R11 direction clear with write", {7'd0, flags}, 16'h0060);

    // R11: no strobes, logical word write leaves control bits
    strobes(6'b000000);
    opcode = 4'd5; size_word = 1'b1; op_a = 16'h8000; op_b = 16'h0000;
    step();
    check("R11 control hold on write", {7'd0, flags}, 16'h0072);
    check("R5 parity of low byte only", {15'd0, flags[1]}, 16'h0001);

    // R12: reset mid-run
    flag_we = 1'b0;
    rst = 1'b1;
    step();
    check("R12 reset mid-run flags", {7'd0, flags}, 16'h0000);
    check("R12 reset mid-run result", result, 16'h0000);
    rst = 1'b0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule